// File: doc/BRIEF.md
# Display Identification Base-Block Parser

This block receives the 128-byte base record that a display uses to describe itself. The record arrives as a stream of bytes, one byte for each cycle in which the valid strobe is high. A start pulse marks the first byte. While the bytes arrive, the block keeps a running byte offset and captures the fields it needs from their fixed positions:

- the product code, serial number and manufacture date;
- whether the video input is digital or analog;
- the physical image size;
- the feature flags byte.

The block does more than store raw bytes. It decodes the eight packed two-byte standard timing records into a horizontal resolution, a vertical resolution and a refresh rate. The vertical resolution is derived from an aspect-ratio code. Each of the four 18-byte descriptor slots is classified by testing its pixel-clock field for zero. The block also checks the modulo-256 sum of the whole record. One cycle after the last byte, it pulses a done flag and shows the checksum result and the count of extension blocks.

The bytes are typically fed by the serial-bus reader of a display port controller. The decoded outputs then feed mode selection logic directly, so no firmware has to parse the record.

Top module: `dispid_base_parser`

## Requirements
- R1: A byte is accepted only in a cycle with `vld_i` high. The first accepted byte after a `sob_i` pulse is offset 0, whether `sob_i` comes with that byte or before it. After offset 127 has been accepted, further bytes are ignored until the next `sob_i`, and all outputs keep their values.
- R2: `prod_code_o` is made of offset 10 (low byte) and offset 11 (high byte). `serial_o` is offsets 12 to 15, least significant byte first. `mfg_week_o` is offset 16. `mfg_year_o` is offset 17 plus 1990.
- R3: `digital_in_o` is bit 7 of offset 20. `img_h_cm_o` is offset 21, `img_v_cm_o` is offset 22, and `features_o` is offset 24.
- R4: Standard timing record i (i = 0 to 7) is held in offsets 38+2i (byte A) and 39+2i (byte B). Its horizontal resolution is A*8+248, and its refresh rate is B[5:0]+60. Both are packed in record order: record i sits in bits [12i+11:12i] of `st_hres_o` and in bits [7i+6:7i] of `st_rate_o`.
- R5: The vertical resolution is the horizontal resolution scaled by the aspect code in B[7:6], rounded down. The codes are 00 for 10/16, 01 for 3/4, 10 for 4/5 and 11 for 9/16. It is packed in bits [12i+11:12i] of `st_vres_o`.
- R6: A record is valid (`st_valid_o[i]`) once its byte B has been accepted, unless A and B are both 01h. While a record is not valid, its resolution and rate fields read zero.
- R7: Descriptor slot d (d = 0 to 3) starts at offset 54+18d. Once its second byte has arrived, `desc_timing_o[d]` is 1 if either of its first two bytes is nonzero. Otherwise the slot is tagged, and bits [8d+7:8d] of `desc_tag_o` show the slot's byte 3 (for example FCh for a name or FDh for range limits). The tag field is zero for timing slots and for slots not yet received.
- R8: `ext_count_o` is the byte at offset 126.
- R9: `done_o` is high for exactly the one cycle after offset 127 is accepted. In that same cycle, `csum_ok_o` becomes 1 if the 8-bit sum of all 128 bytes is zero, and 0 otherwise.
- R10: After reset, and in the cycle after any `sob_i`, every output is zero. This includes a `sob_i` in the middle of a block. A `sob_i` that comes with a byte still records that byte as offset 0.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sob_i | input | 1 | Start of block; restarts the offset and clears the outputs |
| vld_i | input | 1 | Byte strobe |
| byte_i | input | 8 | Record byte |
| prod_code_o | output | 16 | Product code |
| serial_o | output | 32 | Serial number |
| mfg_week_o | output | 8 | Manufacture week |
| mfg_year_o | output | 12 | Manufacture year |
| digital_in_o | output | 1 | Digital input flag |
| img_h_cm_o | output | 8 | Horizontal image size in cm |
| img_v_cm_o | output | 8 | Vertical image size in cm |
| features_o | output | 8 | Feature flags byte |
| st_valid_o | output | 8 | Standard timing record valid flags |
| st_hres_o | output | 96 | Horizontal resolutions, 12 bits per record |
| st_vres_o | output | 96 | Vertical resolutions, 12 bits per record |
| st_rate_o | output | 56 | Refresh rates in Hz, 7 bits per record |
| desc_timing_o | output | 4 | Descriptor slot holds a detailed timing |
| desc_tag_o | output | 32 | Type code of each tagged descriptor slot |
| ext_count_o | output | 8 | Extension block count |
| csum_ok_o | output | 1 | Checksum passed |
| done_o | output | 1 | One-cycle end-of-block pulse |

## Verification
The case that is hardest to reach is a restart in the middle of a block. To reach it, the stimulus sends the first 60 bytes of a record and confirms that some standard timings have been decoded. It then pulses the start signal with no byte and checks that every output has returned to zero. It next streams a new record whose first byte shares its cycle with the start pulse, and confirms that the offset really restarted. A second hard case is a record whose stream has idle gaps and runs on past offset 127. It shows that strobe-less cycles do not advance the offset, and that trailing bytes raise no second done pulse and leave the decoded fields alone.

// File: rtl/dib_pkg.sv
package dib_pkg;
   // Fixed field positions inside the 128-byte base record
   localparam int OFS_PROD  = 10;
   localparam int OFS_SER   = 12;
   localparam int OFS_WEEK  = 16;
   localparam int OFS_YEAR  = 17;
   localparam int OFS_VIN   = 20;
   localparam int OFS_HSZ   = 21;
   localparam int OFS_VSZ   = 22;
   localparam int OFS_FEAT  = 24;
   localparam int OFS_STD   = 38;
   localparam int OFS_DESC  = 54;
   localparam int OFS_EXT   = 126;

   // Aspect ratio codes carried in bits 7:6 of a standard timing byte B
   typedef enum logic [1:0] {
      ASP_16_10 = 2'b00,
      ASP_4_3   = 2'b01,
      ASP_5_4   = 2'b10,
      ASP_16_9  = 2'b11
   } aspect_e;
endpackage

// File: rtl/dib_offset_ctr.sv
module dib_offset_ctr #(
   parameter int BLK_LEN = 128,
   localparam int OFF_W  = $clog2(BLK_LEN)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sob_i,
   input  logic             vld_i,
   output logic [OFF_W-1:0] eff_off_o,
   output logic             take_o,
   output logic             last_o
);
   localparam logic [OFF_W-1:0] LAST_OFF = OFF_W'(BLK_LEN - 1);

   logic [OFF_W-1:0] off_q;
   logic             active_q;

   assign eff_off_o = sob_i ? '0 : off_q;
   assign take_o    = vld_i && (sob_i || active_q);
   assign last_o    = take_o && (eff_off_o == LAST_OFF);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         off_q    <= '0;
         active_q <= 1'b0;
      end else if (last_o) begin
         off_q    <= '0;
         active_q <= 1'b0;
      end else if (take_o) begin
         off_q    <= eff_off_o + 1'b1;
         active_q <= 1'b1;
      end else if (sob_i) begin
         off_q    <= '0;
         active_q <= 1'b1;
      end
   end
endmodule

// File: rtl/dib_std_rec.sv
module dib_std_rec #(
   parameter int BLK_LEN = 128,
   parameter int BASE    = 38,
   parameter int HRES_W  = 12,
   parameter int RATE_W  = 7,
   localparam int OFF_W  = $clog2(BLK_LEN)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr_i,
   input  logic              take_i,
   input  logic [OFF_W-1:0]  off_i,
   input  logic [7:0]        byte_i,
   output logic              valid_o,
   output logic [HRES_W-1:0] hres_o,
   output logic [HRES_W-1:0] vres_o,
   output logic [RATE_W-1:0] rate_o
);
   import dib_pkg::*;

   localparam logic [OFF_W-1:0] OFF_A = OFF_W'(BASE);
   localparam logic [OFF_W-1:0] OFF_B = OFF_W'(BASE + 1);
   localparam int PW = HRES_W + 4;

   logic [7:0] a_q, b_q;
   logic       valid_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         a_q     <= '0;
         b_q     <= '0;
         valid_q <= 1'b0;
      end else begin
         if (clr_i) begin
            a_q     <= '0;
            b_q     <= '0;
            valid_q <= 1'b0;
         end
         if (take_i && off_i == OFF_A) a_q <= byte_i;
         if (take_i && off_i == OFF_B) begin
            b_q     <= byte_i;
            valid_q <= !(a_q == 8'h01 && byte_i == 8'h01);
         end
      end
   end

   logic [HRES_W-1:0] h_raw;
   logic [PW-1:0]     scaled;

   assign h_raw = HRES_W'({a_q, 3'b000}) + HRES_W'(248);

   always_comb begin
      unique case (aspect_e'(b_q[7:6]))
         ASP_16_10: scaled = (PW'(h_raw) * PW'(10)) / PW'(16);
         ASP_4_3:   scaled = (PW'(h_raw) * PW'(3))  / PW'(4);
         ASP_5_4:   scaled = (PW'(h_raw) * PW'(4))  / PW'(5);
         default:   scaled = (PW'(h_raw) * PW'(9))  / PW'(16);
      endcase
   end

   assign valid_o = valid_q;
   assign hres_o  = valid_q ? h_raw : '0;
   assign vres_o  = valid_q ? scaled[HRES_W-1:0] : '0;
   assign rate_o  = valid_q ? (RATE_W'(b_q[5:0]) + RATE_W'(60)) : '0;
endmodule

// File: rtl/dib_desc_cls.sv
module dib_desc_cls #(
   parameter int BLK_LEN = 128,
   parameter int BASE    = 54,
   localparam int OFF_W  = $clog2(BLK_LEN)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr_i,
   input  logic             take_i,
   input  logic [OFF_W-1:0] off_i,
   input  logic [7:0]       byte_i,
   output logic             timing_o,
   output logic [7:0]       tag_o
);
   localparam logic [OFF_W-1:0] OFF_P0  = OFF_W'(BASE);
   localparam logic [OFF_W-1:0] OFF_P1  = OFF_W'(BASE + 1);
   localparam logic [OFF_W-1:0] OFF_TAG = OFF_W'(BASE + 3);

   logic       nz_lo_q, nz_q, seen_q;
   logic [7:0] tag_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         nz_lo_q <= 1'b0;
         nz_q    <= 1'b0;
         seen_q  <= 1'b0;
         tag_q   <= '0;
      end else begin
         if (clr_i) begin
            nz_lo_q <= 1'b0;
            nz_q    <= 1'b0;
            seen_q  <= 1'b0;
            tag_q   <= '0;
         end
         if (take_i && off_i == OFF_P0) nz_lo_q <= |byte_i;
         if (take_i && off_i == OFF_P1) begin
            nz_q   <= nz_lo_q || (|byte_i);
            seen_q <= 1'b1;
         end
         if (take_i && off_i == OFF_TAG) tag_q <= byte_i;
      end
   end

   assign timing_o = seen_q && nz_q;
   assign tag_o    = (seen_q && !nz_q) ? tag_q : 8'h00;
endmodule

// File: rtl/dib_csum.sv
module dib_csum (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       clr_i,
   input  logic       take_i,
   input  logic       last_i,
   input  logic [7:0] byte_i,
   output logic       ok_o,
   output logic       done_o
);
   logic [7:0] sum_q, base, nxt;
   logic       ok_q, done_q;

   assign base = clr_i ? 8'h00 : sum_q;
   assign nxt  = base + byte_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sum_q  <= '0;
         ok_q   <= 1'b0;
         done_q <= 1'b0;
      end else begin
         done_q <= last_i;
         if (take_i)     sum_q <= nxt;
         else if (clr_i) sum_q <= '0;
         if (last_i)     ok_q  <= (nxt == 8'h00);
         else if (clr_i) ok_q  <= 1'b0;
      end
   end

   assign ok_o   = ok_q;
   assign done_o = done_q;
endmodule

// File: rtl/dispid_base_parser.sv
module dispid_base_parser #(
   parameter int BLK_LEN   = 128,
   parameter int N_STD     = 8,
   parameter int N_DESC    = 4,
   parameter int DESC_LEN  = 18,
   parameter int YEAR_BASE = 1990,
   parameter int HRES_W    = 12,
   parameter int RATE_W    = 7,
   parameter int YEAR_W    = 12
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     sob_i,
   input  logic                     vld_i,
   input  logic [7:0]               byte_i,
   output logic [15:0]              prod_code_o,
   output logic [31:0]              serial_o,
   output logic [7:0]               mfg_week_o,
   output logic [YEAR_W-1:0]        mfg_year_o,
   output logic                     digital_in_o,
   output logic [7:0]               img_h_cm_o,
   output logic [7:0]               img_v_cm_o,
   output logic [7:0]               features_o,
   output logic [N_STD-1:0]         st_valid_o,
   output logic [N_STD*HRES_W-1:0]  st_hres_o,
   output logic [N_STD*HRES_W-1:0]  st_vres_o,
   output logic [N_STD*RATE_W-1:0]  st_rate_o,
   output logic [N_DESC-1:0]        desc_timing_o,
   output logic [N_DESC*8-1:0]      desc_tag_o,
   output logic [7:0]               ext_count_o,
   output logic                     csum_ok_o,
   output logic                     done_o
);
   import dib_pkg::*;

   localparam int OFF_W = $clog2(BLK_LEN);

   // Elaboration-time parameter checks
   if (BLK_LEN != 128) begin : g_bad_len
      $error("dispid_base_parser: BLK_LEN must be 128");
   end
   if (OFS_STD + 2 * N_STD > OFS_DESC) begin : g_bad_std
      $error("dispid_base_parser: standard timing area overlaps descriptors");
   end
   if (OFS_DESC + N_DESC * DESC_LEN > OFS_EXT) begin : g_bad_desc
      $error("dispid_base_parser: descriptor area overlaps the trailer");
   end
   if (HRES_W < 12 || RATE_W < 7 || YEAR_W < 12) begin : g_bad_w
      $error("dispid_base_parser: output widths too narrow");
   end

   logic [OFF_W-1:0] eff_off;
   logic             take, last;

   dib_offset_ctr #(.BLK_LEN(BLK_LEN)) u_off (
      .clk(clk), .rst_n(rst_n), .sob_i(sob_i), .vld_i(vld_i),
      .eff_off_o(eff_off), .take_o(take), .last_o(last)
   );

   // Scalar header fields
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prod_code_o  <= '0;
         serial_o     <= '0;
         mfg_week_o   <= '0;
         mfg_year_o   <= '0;
         digital_in_o <= 1'b0;
         img_h_cm_o   <= '0;
         img_v_cm_o   <= '0;
         features_o   <= '0;
         ext_count_o  <= '0;
      end else begin
         if (sob_i) begin
            prod_code_o  <= '0;
            serial_o     <= '0;
            mfg_week_o   <= '0;
            mfg_year_o   <= '0;
            digital_in_o <= 1'b0;
            img_h_cm_o   <= '0;
            img_v_cm_o   <= '0;
            features_o   <= '0;
            ext_count_o  <= '0;
         end
         if (take) begin
            if (eff_off == OFF_W'(OFS_PROD))     prod_code_o[7:0]  <= byte_i;
            if (eff_off == OFF_W'(OFS_PROD + 1)) prod_code_o[15:8] <= byte_i;
            for (int k = 0; k < 4; k++) begin
               if (eff_off == OFF_W'(OFS_SER + k)) serial_o[8*k +: 8] <= byte_i;
            end
            if (eff_off == OFF_W'(OFS_WEEK)) mfg_week_o   <= byte_i;
            if (eff_off == OFF_W'(OFS_YEAR)) mfg_year_o   <= YEAR_W'(byte_i) + YEAR_W'(YEAR_BASE);
            if (eff_off == OFF_W'(OFS_VIN))  digital_in_o <= byte_i[7];
            if (eff_off == OFF_W'(OFS_HSZ))  img_h_cm_o   <= byte_i;
            if (eff_off == OFF_W'(OFS_VSZ))  img_v_cm_o   <= byte_i;
            if (eff_off == OFF_W'(OFS_FEAT)) features_o   <= byte_i;
            if (eff_off == OFF_W'(OFS_EXT))  ext_count_o  <= byte_i;
         end
      end
   end

   // Standard timing decoders, one per record
   for (genvar i = 0; i < N_STD; i++) begin : g_std
      dib_std_rec #(
         .BLK_LEN(BLK_LEN), .BASE(OFS_STD + 2 * i),
         .HRES_W(HRES_W), .RATE_W(RATE_W)
      ) u_rec (
         .clk(clk), .rst_n(rst_n), .clr_i(sob_i), .take_i(take),
         .off_i(eff_off), .byte_i(byte_i),
         .valid_o(st_valid_o[i]),
         .hres_o(st_hres_o[i*HRES_W +: HRES_W]),
         .vres_o(st_vres_o[i*HRES_W +: HRES_W]),
         .rate_o(st_rate_o[i*RATE_W +: RATE_W])
      );
   end

   // Descriptor slot classifiers
   for (genvar d = 0; d < N_DESC; d++) begin : g_desc
      dib_desc_cls #(
         .BLK_LEN(BLK_LEN), .BASE(OFS_DESC + DESC_LEN * d)
      ) u_cls (
         .clk(clk), .rst_n(rst_n), .clr_i(sob_i), .take_i(take),
         .off_i(eff_off), .byte_i(byte_i),
         .timing_o(desc_timing_o[d]),
         .tag_o(desc_tag_o[8*d +: 8])
      );
   end

   dib_csum u_csum (
      .clk(clk), .rst_n(rst_n), .clr_i(sob_i), .take_i(take),
      .last_i(last), .byte_i(byte_i), .ok_o(csum_ok_o), .done_o(done_o)
   );
endmodule

// File: rtl/dib_checker.sv
module dib_checker #(
   parameter int BLK_LEN   = 128,
   parameter int N_STD     = 8,
   parameter int N_DESC    = 4,
   parameter int DESC_LEN  = 18,
   parameter int YEAR_BASE = 1990,
   parameter int HRES_W    = 12,
   parameter int RATE_W    = 7,
   parameter int YEAR_W    = 12
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    sob_i,
   input logic                    vld_i,
   input logic [7:0]              byte_i,
   input logic [15:0]             prod_code_o,
   input logic [31:0]             serial_o,
   input logic [7:0]              mfg_week_o,
   input logic [YEAR_W-1:0]       mfg_year_o,
   input logic                    digital_in_o,
   input logic [7:0]              img_h_cm_o,
   input logic [7:0]              img_v_cm_o,
   input logic [7:0]              features_o,
   input logic [N_STD-1:0]        st_valid_o,
   input logic [N_STD*HRES_W-1:0] st_hres_o,
   input logic [N_STD*HRES_W-1:0] st_vres_o,
   input logic [N_STD*RATE_W-1:0] st_rate_o,
   input logic [N_DESC-1:0]       desc_timing_o,
   input logic [N_DESC*8-1:0]     desc_tag_o,
   input logic [7:0]              ext_count_o,
   input logic                    csum_ok_o,
   input logic                    done_o
);
   p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   p_csum_with_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(csum_ok_o) |-> done_o);

   p_start_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
      sob_i |=> (st_valid_o == '0 && desc_timing_o == '0 && desc_tag_o == '0
                 && !done_o && !csum_ok_o && ext_count_o == 8'h00
                 && mfg_year_o == '0));

   p_year_floor_r2: assert property (@(posedge clk) disable iff (!rst_n)
      mfg_year_o == '0 || mfg_year_o >= YEAR_W'(YEAR_BASE));

   for (genvar i = 0; i < N_STD; i++) begin : g_std_chk
      p_vres_below_r5: assert property (@(posedge clk) disable iff (!rst_n)
         st_valid_o[i] |-> st_vres_o[i*HRES_W +: HRES_W] < st_hres_o[i*HRES_W +: HRES_W]);
      p_rate_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
         st_valid_o[i] |-> (st_rate_o[i*RATE_W +: RATE_W] >= RATE_W'(60)
                            && st_rate_o[i*RATE_W +: RATE_W] <= RATE_W'(123)));
      p_unused_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
         !st_valid_o[i] |-> (st_hres_o[i*HRES_W +: HRES_W] == '0
                             && st_rate_o[i*RATE_W +: RATE_W] == '0));
   end

   for (genvar d = 0; d < N_DESC; d++) begin : g_desc_chk
      p_desc_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
         desc_timing_o[d] |-> desc_tag_o[8*d +: 8] == 8'h00);
   end
endmodule

bind dispid_base_parser dib_checker #(
   .BLK_LEN(BLK_LEN), .N_STD(N_STD), .N_DESC(N_DESC), .DESC_LEN(DESC_LEN),
   .YEAR_BASE(YEAR_BASE), .HRES_W(HRES_W), .RATE_W(RATE_W), .YEAR_W(YEAR_W)
) u_dib_checker (.*);

// File: tb/tb_dispid_base_parser.sv
module tb_dispid_base_parser;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sob_i = 1'b0;
   logic vld_i = 1'b0;
   logic [7:0] byte_i = 8'h00;

   logic [15:0] prod_code_o;
   logic [31:0] serial_o;
   logic [7:0]  mfg_week_o;
   logic [11:0] mfg_year_o;
   logic        digital_in_o;
   logic [7:0]  img_h_cm_o, img_v_cm_o, features_o;
   logic [7:0]  st_valid_o;
   logic [95:0] st_hres_o, st_vres_o;
   logic [55:0] st_rate_o;
   logic [3:0]  desc_timing_o;
   logic [31:0] desc_tag_o;
   logic [7:0]  ext_count_o;
   logic        csum_ok_o, done_o;

   always #2 clk = ~clk;   // 250 MHz

   dispid_base_parser dut (.*);

   typedef struct packed {
      logic [15:0] prod;
      logic [31:0] ser;
      logic [7:0]  week;
      logic [11:0] year;
      logic        dig;
      logic [7:0]  hcm, vcm, feat;
      logic [7:0]  stv;
      logic [95:0] hres, vres;
      logic [55:0] rate;
      logic [3:0]  dtim;
      logic [31:0] dtag;
      logic [7:0]  ext;
      logic        csum;
   } exp_t;

   exp_t q[$];
   exp_t last_exp;
   logic [7:0] blk [128];
   int checks = 0;
   int fails = 0;
   int cyc = 0;

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [95:0] act, input logic [95:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic compare_all(input exp_t e, input bit with_csum);
      chk(prod_code_o == e.prod && serial_o == e.ser && mfg_week_o == e.week
          && mfg_year_o == e.year, "R2", "product/date", {prod_code_o, serial_o, mfg_week_o, mfg_year_o},
          {e.prod, e.ser, e.week, e.year});
      chk(digital_in_o == e.dig && img_h_cm_o == e.hcm && img_v_cm_o == e.vcm
          && features_o == e.feat, "R3", "input/size/features",
          {digital_in_o, img_h_cm_o, img_v_cm_o, features_o}, {e.dig, e.hcm, e.vcm, e.feat});
      chk(st_valid_o == e.stv, "R6", "std valid", st_valid_o, e.stv);
      chk(st_hres_o == e.hres, "R4", "std hres", st_hres_o, e.hres);
      chk(st_rate_o == e.rate, "R4", "std rate", st_rate_o, e.rate);
      chk(st_vres_o == e.vres, "R5", "std vres", st_vres_o, e.vres);
      chk(desc_timing_o == e.dtim && desc_tag_o == e.dtag, "R7", "descriptors",
          {desc_timing_o, desc_tag_o}, {e.dtim, e.dtag});
      chk(ext_count_o == e.ext, "R8", "ext count", ext_count_o, e.ext);
      if (with_csum) chk(csum_ok_o == e.csum, "R9", "checksum flag", csum_ok_o, e.csum);
   endtask

   function automatic exp_t model();
      exp_t e = '0;
      logic [7:0] s = 8'h00;
      e.prod = {blk[11], blk[10]};
      e.ser  = {blk[15], blk[14], blk[13], blk[12]};
      e.week = blk[16];
      e.year = 12'(blk[17]) + 12'd1990;
      e.dig  = blk[20][7];
      e.hcm  = blk[21];
      e.vcm  = blk[22];
      e.feat = blk[24];
      for (int i = 0; i < 8; i++) begin
         logic [7:0] a, b;
         int h, v;
         a = blk[38 + 2*i];
         b = blk[39 + 2*i];
         if (!(a == 8'h01 && b == 8'h01)) begin
            h = int'(a) * 8 + 248;
            case (b[7:6])
               2'd0: v = h * 10 / 16;
               2'd1: v = h * 3 / 4;
               2'd2: v = h * 4 / 5;
               default: v = h * 9 / 16;
            endcase
            e.stv[i] = 1'b1;
            e.hres[12*i +: 12] = 12'(h);
            e.vres[12*i +: 12] = 12'(v);
            e.rate[7*i +: 7]   = 7'(int'(b[5:0]) + 60);
         end
      end
      for (int d = 0; d < 4; d++) begin
         int base;
         base = 54 + 18*d;
         if (blk[base] != 0 || blk[base+1] != 0) e.dtim[d] = 1'b1;
         else e.dtag[8*d +: 8] = blk[base+3];
      end
      e.ext = blk[126];
      for (int k = 0; k < 128; k++) s = s + blk[k];
      e.csum = (s == 8'h00);
      return e;
   endfunction

   task automatic fill(input int mul, input int add);
      for (int k = 0; k < 128; k++) blk[k] = 8'((k * mul + add) & 255);
   endtask

   task automatic seal(input bit good);
      logic [7:0] s = 8'h00;
      for (int k = 0; k < 127; k++) s = s + blk[k];
      blk[127] = 8'(8'h00 - s) + (good ? 8'h00 : 8'h01);
   endtask

   task automatic set_std(input int i, input logic [7:0] a, input logic [7:0] b);
      blk[38 + 2*i] = a;
      blk[39 + 2*i] = b;
   endtask

   task automatic set_desc(input int d, input logic [7:0] p0, input logic [7:0] p1, input logic [7:0] tag);
      blk[54 + 18*d]     = p0;
      blk[54 + 18*d + 1] = p1;
      blk[54 + 18*d + 3] = tag;
   endtask

   // Driver: pushes the expected item, then streams the bytes
   task automatic send(input int nbytes, input bit gaps, input int extra, input bit push);
      if (push) begin
         last_exp = model();
         q.push_back(last_exp);
      end
      for (int k = 0; k < nbytes + extra; k++) begin
         if (gaps && k % 5 == 3) begin
            vld_i = 1'b0; sob_i = 1'b0;
            @(negedge clk);
         end
         sob_i  = (k == 0);
         vld_i  = 1'b1;
         byte_i = (k < 128) ? blk[k] : 8'(8'hA5 + k);
         @(negedge clk);
      end
      sob_i = 1'b0; vld_i = 1'b0; byte_i = 8'h00;
   endtask

   // Monitor: pops expected items on each done pulse
   always @(negedge clk) begin
      if (rst_n && done_o) begin
         if (q.size() == 0) begin
            chk(1'b0, "R9", "unexpected done pulse", 96'd1, 96'd0);
         end else begin
            compare_all(q.pop_front(), 1'b1);
         end
      end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc == 100000) begin
         fails++;
         checks++;
         $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      exp_t zero;
      zero = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R10 reset state
      compare_all(zero, 1'b1);
      chk(done_o == 1'b0, "R10", "done after reset", done_o, 1'b0);

      // Block A: digital, all aspect codes, one unused record, good checksum
      fill(7, 3);
      blk[10] = 8'h75; blk[11] = 8'h07;
      blk[12] = 8'h8C; blk[13] = 8'h2E; blk[14] = 8'h1F; blk[15] = 8'h49;
      blk[16] = 8'd26; blk[17] = 8'd12;
      blk[20] = 8'h81; blk[21] = 8'd32; blk[22] = 8'd24; blk[24] = 8'hEA;
      set_std(0, 8'h81, 8'h40);   // 1280x960 @60
      set_std(1, 8'hD1, 8'hC0);   // 1920x1080 @60
      set_std(2, 8'h81, 8'h8F);   // 1280x1024 @75
      set_std(3, 8'h95, 8'h00);   // 1440x900 @60
      set_std(4, 8'h01, 8'h01);   // unused
      set_std(5, 8'h71, 8'hC5);   // 1152x648 @65
      set_std(6, 8'hFF, 8'h3F);   // 2288x1430 @123
      set_std(7, 8'h00, 8'hC0);   // 248x139 (truncated) @60
      set_desc(0, 8'h2A, 8'h3C, 8'h11);
      set_desc(1, 8'h00, 8'h00, 8'hFC);
      set_desc(2, 8'h00, 8'h00, 8'hFD);
      set_desc(3, 8'h00, 8'h07, 8'h55);
      blk[126] = 8'd1;
      seal(1'b1);
      send(128, 1'b0, 0, 1'b1);
      repeat (3) @(negedge clk);
      chk(q.size() == 0, "R9", "done seen for block A", 96'(q.size()), 96'd0);
      chk(st_rate_o[6:0] == 7'd60 && st_vres_o[11:0] == 12'd960, "R5", "record 0 4:3",
          {st_rate_o[6:0], st_vres_o[11:0]}, {7'd60, 12'd960});

      // Block B: analog, bad checksum, other tag codes, sob separate from byte 0 not used
      fill(13, 5);
      blk[20] = 8'h1E;
      set_std(2, 8'h01, 8'h01);
      set_std(5, 8'h61, 8'h0A);
      set_desc(0, 8'h00, 8'h00, 8'hFF);
      set_desc(1, 8'h00, 8'h05, 8'h00);
      set_desc(2, 8'h00, 8'h00, 8'hFA);
      set_desc(3, 8'h00, 8'h00, 8'hFE);
      blk[126] = 8'd0;
      seal(1'b0);
      send(128, 1'b0, 0, 1'b1);
      repeat (3) @(negedge clk);
      chk(q.size() == 0 && csum_ok_o == 1'b0, "R9", "bad checksum block", {q.size() != 0, csum_ok_o}, 96'd0);

      // Mid-block restart: partial block A pattern, then lone start pulse
      fill(7, 3);
      set_std(0, 8'h81, 8'h40);
      send(60, 1'b1, 0, 1'b0);
      chk(st_valid_o != 8'h00, "R4", "partial block decoded timings", st_valid_o, 96'hFF);
      chk(done_o == 1'b0, "R1", "no done on partial block", done_o, 1'b0);
      sob_i = 1'b1;
      @(negedge clk);
      sob_i = 1'b0;
      compare_all(zero, 1'b1);
      chk(done_o == 1'b0, "R10", "done after restart", done_o, 1'b0);

      // Block C: gaps in the strobe, trailing bytes after offset 127
      fill(29, 101);
      blk[17] = 8'd0;
      set_std(3, 8'h01, 8'h01);
      set_desc(0, 8'h00, 8'h00, 8'hFB);
      set_desc(2, 8'h10, 8'h00, 8'hFC);
      blk[126] = 8'd3;
      seal(1'b1);
      send(128, 1'b1, 6, 1'b1);
      repeat (4) @(negedge clk);
      chk(q.size() == 0, "R1", "exactly one done for gapped block", 96'(q.size()), 96'd0);
      // R1: trailing bytes left every field unchanged
      compare_all(last_exp, 1'b1);
      chk(mfg_year_o == 12'd1990, "R2", "year base", mfg_year_o, 12'd1990);

      // R10: start with byte 0 records it as offset 0 (year field must reflect new block)
      fill(3, 1);
      blk[17] = 8'd30;
      seal(1'b1);
      send(128, 1'b0, 0, 1'b1);
      repeat (3) @(negedge clk);
      chk(mfg_year_o == 12'd2020 && q.size() == 0, "R10", "restart with byte",
          {mfg_year_o, 20'(q.size())}, {12'd2020, 20'd0});

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule